// File: doc/BRIEF.md
# Pulse-and-Verify Programming Sequencer for Byte-Wide UV-Erasable Memory

This controller writes the contents of a source buffer into an external byte-wide, UV-erasable read-only memory. It visits every location in ascending order. At each one it reads the cell, then applies fixed-length program pulses, and it reads the location back after every pulse. It stops pulsing as soon as the stored byte equals the wanted byte. A location therefore receives only as many pulses as it needs. When the pulse budget runs out, or when the wanted byte would require a cleared bit to return to 1, the controller stops at once and reports the failing address.

During this per-address phase the block asks the board for the programming voltage and for the raised core supply. After the last address it drops both requests, which selects the nominal supply level. It then reads the whole array once more and compares every location with the source. The first mismatch in that pass is recorded. A start strobe launches a run. Done is then held high, together with a pass flag and the failing address, until the next start.

The source buffer is read through a plain address/data port, and the data returns in the same cycle. The memory side has an address bus, three active-low strobes (chip select, output enable, program) and a bidirectional data bus.

Top module: `eprom_burn_seq`

## Requirements
- R1: A program pulse lasts exactly PULSE_CYC clock cycles (default 20000, which is 100 µs at 200 MHz). Throughout the pulse the outputs are chip select low, program low and output enable high, the source byte is driven on the data bus, and both supply requests are high.
- R2: Each location is read before its first pulse and again after every pulse. A read holds chip select and output enable low and program high for READ_CYC cycles, with the bus released. The data is sampled in the last of those cycles.
- R3: A location whose read-back equals the source byte receives no further pulse. An already matching location receives zero pulses, and a location that programs after k pulses receives exactly k.
- R4: If a location still mismatches after MAX_PULSES pulses (default 25), no further pulse is given. Done rises with pass low and the failing address recorded.
- R5: If a read shows a bit at 0 where the source byte has a 1, the run aborts at once without pulsing that location. Done rises with pass low and that address recorded.
- R6: Locations are programmed in ascending address order, starting at 0 and ending at 2^ADDR_W-1.
- R7: During the per-address phase, both supply requests stay high. During the final pass both are low, and every location is read with program high.
- R8: The final pass reads every location once in ascending order. The lowest address whose data differs from the source is reported, and pass is low.
- R9: The data bus driver is enabled only during a program pulse. The cycle after a pulse always has chip select high and the bus released, before output enable falls.
- R10: After reset, done is low, all three strobes are high and both supply requests are low. Once done rises, done, pass and the failing address hold until the next start, with the memory deselected.
- R11: A run in which every location programs and verifies ends with pass high and a failing address of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Starts a run when idle or done |
| done_o | output | 1 | Run finished; held until the next start |
| pass_o | output | 1 | High with done when the run succeeded |
| fail_addr_o | output | ADDR_W | First failing address (0 on pass) |
| src_addr_o | output | ADDR_W | Source buffer read address |
| src_data_i | input | DATA_W | Source byte for src_addr_o, same cycle |
| mem_addr_o | output | ADDR_W | Memory address |
| mem_ce_n_o | output | 1 | Memory chip select, active low |
| mem_oe_n_o | output | 1 | Memory output enable, active low |
| mem_pgm_n_o | output | 1 | Memory program strobe, active low |
| mem_dq_io | inout | DATA_W | Memory data bus |
| vpp_prog_o | output | 1 | Request for the programming voltage |
| vcc_raise_o | output | 1 | Request for the raised core supply |

## Verification
The assertions assume the memory drives the bus only while chip select and output enable are both low. They also assume the source byte for the current address stays stable while the run is in progress, and that start is pulsed only when the block is idle or done. The bench memory model follows these rules. It drives the bus only in read cycles and changes a cell only at the end of a pulse. The source array is loaded before each start and left unchanged until done. Start is raised for a single cycle, at a point where done is already high or the block has just left reset.

// File: rtl/eprom_burn_pkg.sv
package eprom_burn_pkg;
  localparam int DATA_W = 8;

  typedef enum logic [2:0] {
    PH_IDLE, PH_READ, PH_PULSE, PH_GAP, PH_NEXT, PH_FINAL, PH_DONE
  } phase_t;

  // a wanted 1 over a stored 0 cannot be reached by programming
  function automatic logic needs_raise(input logic [DATA_W-1:0] cur,
                                       input logic [DATA_W-1:0] want);
    return |(want & ~cur);
  endfunction

  function automatic logic byte_equal(input logic [DATA_W-1:0] cur,
                                      input logic [DATA_W-1:0] want);
    return (cur ^ want) == '0;
  endfunction
endpackage

// File: rtl/eprom_burn_delay.sv
module eprom_burn_delay #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_o <= '0;
    else if (clr_i) cnt_o <= '0;
    else            cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/eprom_burn_strobes.sv
module eprom_burn_strobes
  import eprom_burn_pkg::*;
(
  input  phase_t ph_i,
  output logic   ce_n_o,
  output logic   oe_n_o,
  output logic   pgm_n_o,
  output logic   drv_en_o,
  output logic   vpp_o,
  output logic   vcc_o
);
  logic prog_phase;

  always_comb begin
    prog_phase = (ph_i == PH_READ) || (ph_i == PH_PULSE) ||
                 (ph_i == PH_GAP)  || (ph_i == PH_NEXT);
    ce_n_o   = !((ph_i == PH_READ) || (ph_i == PH_PULSE) || (ph_i == PH_FINAL));
    oe_n_o   = !((ph_i == PH_READ) || (ph_i == PH_FINAL));
    pgm_n_o  = !(ph_i == PH_PULSE);
    drv_en_o = (ph_i == PH_PULSE);
    vpp_o    = prog_phase;
    vcc_o    = prog_phase;
  end
endmodule

// File: rtl/eprom_burn_seq.sv
module eprom_burn_seq
  import eprom_burn_pkg::*;
#(
  parameter int ADDR_W     = 18,
  parameter int PULSE_CYC  = 20000,
  parameter int READ_CYC   = 2,
  parameter int MAX_PULSES = 25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  output logic              done_o,
  output logic              pass_o,
  output logic [ADDR_W-1:0] fail_addr_o,
  output logic [ADDR_W-1:0] src_addr_o,
  input  logic [DATA_W-1:0] src_data_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_ce_n_o,
  output logic              mem_oe_n_o,
  output logic              mem_pgm_n_o,
  inout  wire  [DATA_W-1:0] mem_dq_io,
  output logic              vpp_prog_o,
  output logic              vcc_raise_o
);
  localparam int TMAX = (PULSE_CYC > READ_CYC) ? PULSE_CYC : READ_CYC;
  localparam int TW   = $clog2(TMAX + 1);
  localparam int PW   = $clog2(MAX_PULSES + 1);

  phase_t            ph_q, ph_nx;
  logic [ADDR_W-1:0] addr_q;
  logic [PW-1:0]     pulses_q;
  logic              failed_q;
  logic [ADDR_W-1:0] fail_addr_q;
  logic [TW-1:0]     tmr_q;
  logic              tmr_clr;
  logic [DATA_W-1:0] dq_in;

  // named events used by the checker
  logic read_sample, prog_sample, final_sample, pulse_end;
  logic raise_hit, byte_ok, limit_hit, last_addr, dq_drv_en;

  assign dq_in        = mem_dq_io;
  assign read_sample  = ((ph_q == PH_READ) || (ph_q == PH_FINAL)) &&
                        (tmr_q == TW'(READ_CYC - 1));
  assign prog_sample  = read_sample && (ph_q == PH_READ);
  assign final_sample = read_sample && (ph_q == PH_FINAL);
  assign pulse_end    = (ph_q == PH_PULSE) && (tmr_q == TW'(PULSE_CYC - 1));
  assign raise_hit    = needs_raise(dq_in, src_data_i);
  assign byte_ok      = byte_equal(dq_in, src_data_i);
  assign limit_hit    = (pulses_q == PW'(MAX_PULSES));
  assign last_addr    = &addr_q;

  always_comb begin
    ph_nx = ph_q;
    unique case (ph_q)
      PH_IDLE, PH_DONE: if (start_i) ph_nx = PH_READ;
      PH_READ: if (prog_sample) begin
        if (raise_hit)      ph_nx = PH_DONE;
        else if (byte_ok)   ph_nx = PH_NEXT;
        else if (limit_hit) ph_nx = PH_DONE;
        else                ph_nx = PH_PULSE;
      end
      PH_PULSE: if (pulse_end) ph_nx = PH_GAP;
      PH_GAP:   ph_nx = PH_READ;
      PH_NEXT:  ph_nx = last_addr ? PH_FINAL : PH_READ;
      PH_FINAL: if (final_sample && last_addr) ph_nx = PH_DONE;
      default:  ph_nx = PH_IDLE;
    endcase
    tmr_clr = (ph_nx != ph_q) || final_sample;
  end

  eprom_burn_delay #(.W(TW)) u_delay (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_i (tmr_clr),
    .cnt_o (tmr_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q        <= PH_IDLE;
      addr_q      <= '0;
      pulses_q    <= '0;
      failed_q    <= 1'b0;
      fail_addr_q <= '0;
    end else begin
      ph_q <= ph_nx;
      unique case (ph_q)
        PH_IDLE, PH_DONE: if (start_i) begin
          addr_q      <= '0;
          pulses_q    <= '0;
          failed_q    <= 1'b0;
          fail_addr_q <= '0;
        end
        PH_READ: if (prog_sample) begin
          if (raise_hit || (!byte_ok && limit_hit)) begin
            failed_q    <= 1'b1;
            fail_addr_q <= addr_q;
          end else if (!byte_ok) begin
            pulses_q <= pulses_q + PW'(1);
          end
        end
        PH_NEXT: begin
          pulses_q <= '0;
          addr_q   <= last_addr ? '0 : addr_q + 1'b1;
        end
        PH_FINAL: if (final_sample) begin
          if (!byte_ok && !failed_q) begin
            failed_q    <= 1'b1;
            fail_addr_q <= addr_q;
          end
          if (!last_addr) addr_q <= addr_q + 1'b1;
        end
        default: ;
      endcase
    end
  end

  eprom_burn_strobes u_strobes (
    .ph_i     (ph_q),
    .ce_n_o   (mem_ce_n_o),
    .oe_n_o   (mem_oe_n_o),
    .pgm_n_o  (mem_pgm_n_o),
    .drv_en_o (dq_drv_en),
    .vpp_o    (vpp_prog_o),
    .vcc_o    (vcc_raise_o)
  );

  assign mem_dq_io   = dq_drv_en ? src_data_i : {DATA_W{1'bz}};
  assign mem_addr_o  = addr_q;
  assign src_addr_o  = addr_q;
  assign done_o      = (ph_q == PH_DONE);
  assign pass_o      = done_o && !failed_q;
  assign fail_addr_o = fail_addr_q;
endmodule

// File: rtl/eprom_burn_chk.sv
module eprom_burn_chk #(
  parameter int ADDR_W     = 18,
  parameter int PULSE_CYC  = 20000,
  parameter int MAX_PULSES = 25,
  parameter int PW         = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              done_o,
  input logic              pass_o,
  input logic [ADDR_W-1:0] fail_addr_o,
  input logic              ce_n,
  input logic              oe_n,
  input logic              pgm_n,
  input logic              drv_en,
  input logic              vpp,
  input logic              vcc,
  input logic              prog_sample,
  input logic              raise_hit,
  input logic              byte_ok,
  input logic [PW-1:0]     pulses
);
  localparam int LW = $clog2(PULSE_CYC + 1) + 1;
  logic [LW-1:0] run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      run_len <= '0;
    else if (drv_en) run_len <= run_len + 1'b1;
    else             run_len <= '0;
  end

  AST_PULSE_PINS: assert property (@(posedge clk) disable iff (!rst_n)
    drv_en |-> (!ce_n && !pgm_n && oe_n && vpp && vcc)); // R1
  AST_PULSE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(drv_en) |-> (run_len == LW'(PULSE_CYC))); // R1
  AST_READ_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> (!drv_en && pgm_n)); // R2
  AST_MATCH_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_sample && byte_ok) |=> !drv_en); // R3
  AST_PULSE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    pulses <= PW'(MAX_PULSES)); // R4
  AST_LIMIT_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_sample && !byte_ok && !raise_hit && pulses == PW'(MAX_PULSES)) |=> (done_o && !pass_o)); // R4
  AST_RAISE_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_sample && raise_hit) |=> (done_o && !pass_o)); // R5
  AST_FINAL_SUPPLY: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && !vcc) |-> (!vpp && pgm_n && !oe_n)); // R7
  AST_RELEASE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(drv_en) |-> ce_n); // R9
  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start_i) |=> (done_o && $stable(pass_o) && $stable(fail_addr_o))); // R10
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (ce_n && !vpp && !vcc)); // R10
endmodule

bind eprom_burn_seq eprom_burn_chk #(
  .ADDR_W(ADDR_W), .PULSE_CYC(PULSE_CYC), .MAX_PULSES(MAX_PULSES), .PW(PW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .done_o(done_o),
  .pass_o(pass_o), .fail_addr_o(fail_addr_o), .ce_n(mem_ce_n_o),
  .oe_n(mem_oe_n_o), .pgm_n(mem_pgm_n_o), .drv_en(dq_drv_en),
  .vpp(vpp_prog_o), .vcc(vcc_raise_o), .prog_sample(prog_sample),
  .raise_hit(raise_hit), .byte_ok(byte_ok), .pulses(pulses_q)
);

// File: tb/tb_eprom_burn_seq.sv
`timescale 1ns/1ps
module tb_eprom_burn_seq;
  localparam int AW = 4;
  localparam int N  = 1 << AW;
  localparam int PC = 6;
  localparam int RC = 2;
  localparam int MP = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic done, pass, ce_n, oe_n, pgm_n, vpp, vcc;
  logic [AW-1:0] fail_addr, src_addr, mem_addr;
  logic [7:0] src_data;
  wire  [7:0] dq;

  logic [7:0] mem    [N];
  logic [7:0] init_m [N];
  logic [7:0] tgt_m  [N];
  logic [7:0] dist_m [N];
  int need [N];
  int pcnt [N];
  int exp_pc [N];
  logic [7:0] exp_mem [N];

  int checks = 0, fails = 0, cycles = 0;
  int run = 0, len_viol = 0, gap_viol = 0, sup_viol = 0, ord_viol = 0, fin_cnt = 0;
  int last_ad = 0, paddr = 0;
  logic [7:0] pdata;
  bit inject_pend = 0;
  bit exp_pass;
  int exp_fa, exp_fin;

  always #2.5 clk = ~clk;

  assign src_data = tgt_m[src_addr];
  assign dq = (!ce_n && !oe_n) ? mem[mem_addr] : 8'bz;

  eprom_burn_seq #(.ADDR_W(AW), .PULSE_CYC(PC), .READ_CYC(RC), .MAX_PULSES(MP)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .done_o(done), .pass_o(pass),
    .fail_addr_o(fail_addr), .src_addr_o(src_addr), .src_data_i(src_data),
    .mem_addr_o(mem_addr), .mem_ce_n_o(ce_n), .mem_oe_n_o(oe_n),
    .mem_pgm_n_o(pgm_n), .mem_dq_io(dq), .vpp_prog_o(vpp), .vcc_raise_o(vcc)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // memory model: cells change only when a pulse ends
  always @(negedge clk) if (rst_n) begin
    cycles++;
    if (!pgm_n && !ce_n) begin
      if (!vpp || !vcc || !oe_n) sup_viol++;
      run++;
      pdata = dq;
      paddr = int'(mem_addr);
    end else if (run != 0) begin
      if (run != PC) len_viol++;
      if (!ce_n) gap_viol++;
      pcnt[paddr]++;
      if (pcnt[paddr] >= need[paddr]) mem[paddr] = mem[paddr] & pdata;
      run = 0;
    end
    if (!ce_n && !oe_n && vcc) begin
      if (int'(mem_addr) < last_ad) ord_viol++;
      last_ad = int'(mem_addr);
    end
    if (!ce_n && !oe_n && !vcc && !vpp) begin
      fin_cnt++;
      if (inject_pend) begin
        for (int a = 0; a < N; a++) mem[a] = mem[a] ^ dist_m[a];
        inject_pend = 0;
      end
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(negedge clk) if (cycles > 190000) begin
    checks++; fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
    finish_run();
  end

  // expected outcome computed from the requirements
  task automatic compute_expect();
    bit early = 0;
    int first_d = -1;
    exp_pass = 1; exp_fa = 0; exp_fin = 0;
    for (int a = 0; a < N; a++) begin
      exp_pc[a] = 0;
      exp_mem[a] = init_m[a];
      if (!early && init_m[a] != tgt_m[a]) begin
        if ((tgt_m[a] & ~init_m[a]) != 0) begin
          early = 1; exp_fa = a;                       // R5
        end else if (need[a] > MP) begin
          early = 1; exp_fa = a; exp_pc[a] = MP;       // R4
        end else begin
          exp_pc[a] = need[a]; exp_mem[a] = tgt_m[a];  // R3
        end
      end
    end
    if (early) exp_pass = 0;
    else begin
      exp_fin = N * RC;
      for (int a = 0; a < N; a++) if (dist_m[a] != 0) begin
        exp_mem[a] = exp_mem[a] ^ dist_m[a];
        if (first_d < 0) first_d = a;
      end
      if (first_d >= 0) begin exp_pass = 0; exp_fa = first_d; end
    end
  endtask

  task automatic run_case(input string name);
    int n = 0, mm = 0;
    logic p0;
    logic [AW-1:0] f0;
    compute_expect();
    @(negedge clk);
    for (int a = 0; a < N; a++) begin mem[a] = init_m[a]; pcnt[a] = 0; end
    len_viol = 0; gap_viol = 0; sup_viol = 0; ord_viol = 0; fin_cnt = 0; last_ad = 0;
    inject_pend = 1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done && n < 20000) begin @(negedge clk); n++; end
    check(done == 1'b1, {name, " R10 done"}, done, 1);
    if (!done) finish_run();
    check(pass == exp_pass, {name, " R11/R8 pass"}, pass, exp_pass);
    check(int'(fail_addr) == exp_fa, {name, " R4/R5/R8 fail_addr"}, fail_addr, exp_fa);
    for (int a = 0; a < N; a++)
      check(pcnt[a] == exp_pc[a], {name, " R3 R2 pulse count"}, pcnt[a], exp_pc[a]);
    for (int a = 0; a < N; a++) if (mem[a] != exp_mem[a]) mm++;
    check(mm == 0, {name, " R8 memory contents"}, mm, 0);
    check(len_viol == 0, {name, " R1 pulse length"}, len_viol, 0);
    check(gap_viol == 0, {name, " R9 release gap"}, gap_viol, 0);
    check(sup_viol == 0, {name, " R7 supply during pulse"}, sup_viol, 0);
    check(ord_viol == 0, {name, " R6 address order"}, ord_viol, 0);
    check(fin_cnt == exp_fin, {name, " R7 final pass reads"}, fin_cnt, exp_fin);
    p0 = pass; f0 = fail_addr;
    repeat (5) @(negedge clk);
    check(done && pass == p0 && fail_addr == f0 && ce_n, {name, " R10 hold"}, done, 1);
  endtask

  task automatic clear_setup();
    for (int a = 0; a < N; a++) begin
      init_m[a] = 8'hFF; tgt_m[a] = 8'hFF; dist_m[a] = 8'h00; need[a] = 1;
    end
  endtask

  initial begin
    void'($urandom(32'h5A17));
    clear_setup();
    for (int a = 0; a < N; a++) mem[a] = 8'hFF;
    repeat (3) @(negedge clk);
    check(!done && ce_n && oe_n && pgm_n && !vpp && !vcc, "R10 reset state", done, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // erased array, ascending pulse needs
    clear_setup();
    for (int a = 0; a < N; a++) begin tgt_m[a] = 8'(a * 37 + 5); need[a] = 1 + (a % 3); end
    run_case("erased");

    // some locations already match: zero pulses
    clear_setup();
    for (int a = 0; a < N; a++) begin
      tgt_m[a] = 8'(a * 11); init_m[a] = (a % 2 == 0) ? tgt_m[a] : 8'hFF; need[a] = 2;
    end
    run_case("prematched");

    // a bit would have to go back to 1 at address 5
    clear_setup();
    for (int a = 0; a < N; a++) tgt_m[a] = 8'hF0;
    init_m[5] = 8'h70;
    run_case("raise_R5");

    // address 9 never programs: pulse limit
    clear_setup();
    for (int a = 0; a < N; a++) tgt_m[a] = 8'h3C;
    need[9] = MP + 1;
    run_case("limit_R4");

    // exactly MAX pulses is still a success
    clear_setup();
    for (int a = 0; a < N; a++) begin tgt_m[a] = 8'h81; need[a] = MP; end
    run_case("limit_edge");

    // final pass disturbances at 3 and 11: first reported
    clear_setup();
    for (int a = 0; a < N; a++) tgt_m[a] = 8'hA5;
    dist_m[11] = 8'h02; dist_m[3] = 8'h40;
    run_case("final_R8");

    // random runs
    for (int r = 0; r < 8; r++) begin
      clear_setup();
      for (int a = 0; a < N; a++) begin
        int k = int'($urandom % 16);
        tgt_m[a] = 8'($urandom);
        init_m[a] = (k < 3) ? tgt_m[a] : (k < 13 ? 8'hFF : (tgt_m[a] | 8'($urandom)));
        need[a] = 1 + int'($urandom % 3);
        if ($urandom % 40 == 0) need[a] = MP + 1;
        if ($urandom % 60 == 0) init_m[a] = tgt_m[a] & 8'hFE;
        if ($urandom % 30 == 0) dist_m[a] = 8'h10;
      end
      run_case($sformatf("random%0d", r));
    end
    finish_run();
  end
endmodule